// File: doc/BRIEF.md
# Programmable Clock Output Control

This block is the digital back end of a programmable clock generator. It takes the reference clock, a clock already produced by an external PLL, and one multi-function control pin. From these it builds two clock outputs. Two static configuration words are held at its inputs. Each word chooses a post-divide value and a source for each output, and the control pin can pick between the two words. The reference clock also clocks the block's own registers.

The control pin is given one of four roles. As an output enable, a low pin silences the main output while the secondary output keeps running. As a power-down, a low pin silences both outputs and clears every divider. As a frequency select, the pin chooses the configuration word, and a change of word takes effect only at the end of a whole divided period, so no output pulse is ever cut short. The fourth role ignores the pin. Each output has its own enable and data signal for an external tristate buffer. A silenced output is either released (enable low) or driven low, and a separate input per output chooses which.

Top module: `ckout_ctrl`

## Requirements
- R1: While reset is asserted, and until the internal reset release, both data outputs are low. Each output enable during that time equals the inverse of that output's high-impedance select.
- R2: A configuration word is packed as {clk1 source[8:7], clk0 source[6:5], P[4:0]}. The clk0 source codes are: 0 gives the PLL clock, 1 gives the reference clock, and 2 or 3 give the reference divided by 2·P. The divided clock has 50% duty and stays high for P reference cycles, then low for P reference cycles.
- R3: The clk1 source codes are: 0 gives the reference, 1 gives the reference divided by 2, 2 gives the selected clk0 source taken before gating, and 3 gives that source divided by 2 with 50% duty. That source divided by 2 is the PLL clock divided by 2, the reference divided by 2, or the reference divided by 4·P.
- R4: A post-divide value of P = 0 divides exactly as P = 1 does.
- R5: The role codes are 0 output enable, 1 power-down, 2 frequency select and 3 pin ignored. The pin passes through a two-stage synchronizer and reads as 1 during reset. A pin change reaches the outputs after the second rising reference edge.
- R6: In output-enable role, a low pin silences clk0, and clk1 keeps its enable high and keeps toggling.
- R7: In power-down role, a low pin silences both outputs and clears all dividers to their low phase. When the pin returns high, division resumes at the programmed ratio.
- R8: A silenced output has data low. Its enable is low when its high-impedance select is 1, and high when the select is 0.
- R9: In frequency-select role, a high pin selects word A and a low pin selects word B. The switch takes effect only at the falling edge of the divided clock, so every high or low phase of the divided clock lasts either word A's or word B's P.
- R10: In every role other than frequency select, word A is in use. In pin-ignored role, a low pin leaves both outputs enabled and running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; clocks the block and is a source |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pll_clk_i | input | 1 | Synthesized PLL clock, used as a source |
| ctl_pin_i | input | 1 | Multi-function control pin (pulled up externally) |
| pin_role_i | input | 2 | Role of the control pin |
| cfg_a_i | input | 9 | Configuration word A (pin high) |
| cfg_b_i | input | 9 | Configuration word B (pin low, select role) |
| hiz0_i | input | 1 | clk0 silenced state: 1 released, 0 driven low |
| hiz1_i | input | 1 | clk1 silenced state: 1 released, 0 driven low |
| clk0_o | output | 1 | Main clock data |
| clk0_en_o | output | 1 | Main clock output-buffer enable |
| clk1_o | output | 1 | Secondary clock data |
| clk1_en_o | output | 1 | Secondary clock output-buffer enable |

## Verification
Some properties are checked on every cycle. Power-down holds both data outputs low. Output-enable role never releases clk1, and pin-ignored role keeps both enables high. A released output is always silent and has its high-impedance select set. A word switch coincides with a falling edge of the divided clock, and a stopped divider is fully cleared. The bench scenarios show what those checks cannot. They check the exact half-period for every P from 0 to 31 on both outputs, and the behaviour of the reference and PLL pass-through paths. They check the synchronizer latency of the pin and that a word switch leaves no runt phase. They also check that division resumes correctly after a power-down.

// File: rtl/ckout_pkg.sv
`timescale 1ns/1ps
package ckout_pkg;
  localparam int PW    = 5;
  localparam int SEL_W = 2;
  localparam int CFG_W = 2 * SEL_W + PW;

  typedef enum logic [1:0] {
    ROLE_OE   = 2'd0,
    ROLE_PDN  = 2'd1,
    ROLE_FSEL = 2'd2,
    ROLE_NONE = 2'd3
  } pin_role_e;

  typedef enum logic [SEL_W-1:0] {
    C0_PLL  = 2'd0,
    C0_REF  = 2'd1,
    C0_DIV  = 2'd2,
    C0_DIVX = 2'd3
  } c0_src_e;

  typedef enum logic [SEL_W-1:0] {
    C1_REF   = 2'd0,
    C1_REFH  = 2'd1,
    C1_C0    = 2'd2,
    C1_C0H   = 2'd3
  } c1_src_e;

  typedef struct packed {
    logic [SEL_W-1:0] c1_sel;
    logic [SEL_W-1:0] c0_sel;
    logic [PW-1:0]    pdiv;
  } out_cfg_t;
endpackage

// File: rtl/ckout_sync.sv
`timescale 1ns/1ps
module ckout_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ckout_refdiv.sv
`timescale 1ns/1ps
module ckout_refdiv
  import ckout_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  logic     want_b_i,
  input  out_cfg_t cfg_a_i,
  input  out_cfg_t cfg_b_i,
  output out_cfg_t cfg_o,
  output logic     div_o,
  output logic     quad_o,
  output logic     half_o
);
  logic [PW-1:0] cnt_q, cnt_d, term;
  logic          div_q, div_d;
  logic          quad_q, quad_d;
  logic          half_q, half_d;
  logic          useb_q, useb_d;
  logic          at_term;
  out_cfg_t      act;

  always_comb begin
    act     = useb_q ? cfg_b_i : cfg_a_i;
    term    = (act.pdiv == '0) ? '0 : act.pdiv - 1'b1;
    at_term = (cnt_q >= term);
  end

  always_comb begin
    cnt_d  = cnt_q;
    div_d  = div_q;
    quad_d = quad_q;
    half_d = half_q;
    useb_d = useb_q;
    if (!run_i) begin
      cnt_d  = '0;
      div_d  = 1'b0;
      quad_d = 1'b0;
      half_d = 1'b0;
    end else begin
      half_d = ~half_q;
      if (at_term) begin
        cnt_d = '0;
        div_d = ~div_q;
        if (div_q) begin
          quad_d = ~quad_q;
          useb_d = want_b_i;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      quad_q <= 1'b0;
      half_q <= 1'b0;
      useb_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      quad_q <= quad_d;
      half_q <= half_d;
      useb_q <= useb_d;
    end
  end

  assign cfg_o  = act;
  assign div_o  = div_q;
  assign quad_o = quad_q;
  assign half_o = half_q;

  // R9: word change lands only on a falling edge of the divided clock
  p_switch_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(useb_q) |-> $fell(div_q));

  // R7: a stopped divider is cleared to its low phase
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && !div_q && !quad_q && !half_q));

  // R3: the divide-by-two of the divided clock moves only on its falling edge
  p_quad_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(quad_q) && $past(run_i)) |-> $fell(div_q));
endmodule

// File: rtl/ckout_pll_half.sv
`timescale 1ns/1ps
module ckout_pll_half #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pll_clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_o
);
  logic prst_n, prun;
  logic half_q, half_d;

  ckout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst (
    .clk(pll_clk), .rst_n(rst_n), .d(1'b1), .q(prst_n));

  ckout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run (
    .clk(pll_clk), .rst_n(prst_n), .d(run_i), .q(prun));

  always_comb half_d = prun ? ~half_q : 1'b0;

  always_ff @(posedge pll_clk or negedge prst_n) begin
    if (!prst_n) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  assign half_o = half_q;
endmodule

// File: rtl/ckout_ctrl.sv
`timescale 1ns/1ps
module ckout_ctrl
  import ckout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk_i,
  input  logic             rst_n_i,
  input  logic             pll_clk_i,
  input  logic             ctl_pin_i,
  input  logic [1:0]       pin_role_i,
  input  logic [CFG_W-1:0] cfg_a_i,
  input  logic [CFG_W-1:0] cfg_b_i,
  input  logic             hiz0_i,
  input  logic             hiz1_i,
  output logic             clk0_o,
  output logic             clk0_en_o,
  output logic             clk1_o,
  output logic             clk1_en_o
);
  localparam int LANES = 2;

  logic      rst_ref_n, pin_s;
  pin_role_e role;
  logic      pdn_low, oe_low, want_b, run;
  out_cfg_t  cfg_a, cfg_b, act;
  logic      div_clk, quad_clk, ref_half, pll_half;
  logic      c0_src, c0_src_half;
  logic [LANES-1:0] lane_src, lane_off, lane_hiz, lane_dat, lane_en;

  ckout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(ref_clk_i), .rst_n(rst_n_i), .d(1'b1), .q(rst_ref_n));

  ckout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(ref_clk_i), .rst_n(rst_ref_n), .d(ctl_pin_i), .q(pin_s));

  always_comb begin
    role    = pin_role_e'(pin_role_i);
    cfg_a   = out_cfg_t'(cfg_a_i);
    cfg_b   = out_cfg_t'(cfg_b_i);
    pdn_low = (role == ROLE_PDN)  && !pin_s;
    oe_low  = (role == ROLE_OE)   && !pin_s;
    want_b  = (role == ROLE_FSEL) && !pin_s;
    run     = rst_ref_n && !pdn_low;
  end

  ckout_refdiv u_refdiv (
    .clk(ref_clk_i), .rst_n(rst_ref_n), .run_i(run), .want_b_i(want_b),
    .cfg_a_i(cfg_a), .cfg_b_i(cfg_b), .cfg_o(act),
    .div_o(div_clk), .quad_o(quad_clk), .half_o(ref_half));

  ckout_pll_half #(.SYNC_STAGES(SYNC_STAGES)) u_pll_half (
    .pll_clk(pll_clk_i), .rst_n(rst_n_i), .run_i(run), .half_o(pll_half));

  always_comb begin
    case (c0_src_e'(act.c0_sel))
      C0_PLL:  begin c0_src = pll_clk_i; c0_src_half = pll_half; end
      C0_REF:  begin c0_src = ref_clk_i; c0_src_half = ref_half; end
      default: begin c0_src = div_clk;   c0_src_half = quad_clk; end
    endcase
  end

  always_comb begin
    lane_src[0] = c0_src;
    case (c1_src_e'(act.c1_sel))
      C1_REF:  lane_src[1] = ref_clk_i;
      C1_REFH: lane_src[1] = ref_half;
      C1_C0:   lane_src[1] = c0_src;
      default: lane_src[1] = c0_src_half;
    endcase
    lane_off[0] = !rst_ref_n || pdn_low || oe_low;
    lane_off[1] = !rst_ref_n || pdn_low;
    lane_hiz    = {hiz1_i, hiz0_i};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_dat[i] = lane_src[i] & ~lane_off[i];
    assign lane_en[i]  = ~(lane_off[i] & lane_hiz[i]);
  end

  assign clk0_o    = lane_dat[0];
  assign clk0_en_o = lane_en[0];
  assign clk1_o    = lane_dat[1];
  assign clk1_en_o = lane_en[1];

  // R7: power-down silences both data outputs
  p_pdn_silences_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    pdn_low |-> (!clk0_o && !clk1_o));

  // R6: output-enable role never releases the secondary output
  p_oe_keeps_clk1_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    (role == ROLE_OE) |-> clk1_en_o);

  // R8: a released output is silent and had its high-impedance select set
  p_release_state_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    (!clk0_en_o |-> (hiz0_i && !clk0_o)) and (!clk1_en_o |-> (hiz1_i && !clk1_o)));

  // R10: pin-ignored role keeps both outputs enabled
  p_pin_ignored_r10: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    (role == ROLE_NONE) |-> (clk0_en_o && clk1_en_o));
endmodule

// File: tb/ckout_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckout_ctrl_tb_top;
  logic       ref_clk, rst_n, pll_clk, pin;
  logic [1:0] role;
  logic [8:0] cfg_a, cfg_b;
  logic       hiz0, hiz1;
  logic       clk0, en0, clk1, en1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int runs[64];
  int nruns;
  int e0, e1;

  ckout_ctrl dut_i (
    .ref_clk_i(ref_clk), .rst_n_i(rst_n), .pll_clk_i(pll_clk), .ctl_pin_i(pin),
    .pin_role_i(role), .cfg_a_i(cfg_a), .cfg_b_i(cfg_b), .hiz0_i(hiz0), .hiz1_i(hiz1),
    .clk0_o(clk0), .clk0_en_o(en0), .clk1_o(clk1), .clk1_en_o(en1));

  initial ref_clk = 1'b0;
  always #10 ref_clk = ~ref_clk;
  initial pll_clk = 1'b0;
  always #3 pll_clk = ~pll_clk;

  always @(posedge clk0) e0++;
  always @(posedge clk1) e1++;

  function automatic logic [8:0] mk(input int c1, input int c0, input int p);
    logic [1:0] a, b;
    logic [4:0] c;
    a = c1[1:0]; b = c0[1:0]; c = p[4:0];
    return {a, b, c};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge ref_clk);
    @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (4) @(posedge ref_clk);
  endtask

  task automatic measure(input bit which, input int n);
    bit prev, v, seen;
    int len;
    nruns = 0; seen = 0; len = 0;
    @(posedge ref_clk); #5;
    prev = which ? clk1 : clk0;
    repeat (n) begin
      @(posedge ref_clk); #5;
      v = which ? clk1 : clk0;
      len++;
      if (v != prev) begin
        if (seen && nruns < 64) begin runs[nruns] = len; nruns++; end
        seen = 1; len = 0; prev = v;
      end
    end
  endtask

  task automatic check_runs(input int a, input int b, input string tag);
    int first_bad;
    bit ok;
    ok = (nruns >= 2);
    first_bad = ok ? a : -1;
    for (int k = 0; k < nruns; k++)
      if (runs[k] != a && runs[k] != b) begin
        if (ok) first_bad = runs[k];
        ok = 0;
      end
    check(ok, tag, first_bad, a);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 1'b1; role = 2'd3; hiz0 = 1'b1; hiz1 = 1'b0;
    cfg_a = mk(0, 1, 1); cfg_b = mk(0, 1, 1);

    // R1: reset state with reference pass-through selected
    repeat (3) @(posedge ref_clk);
    #5;
    check(clk0 == 0 && clk1 == 0, "R1 data low (ref high phase)", {clk0, clk1}, 0);
    check(en0 == 0 && en1 == 1, "R1 enables follow hiz", {en0, en1}, 1);
    #10;
    check(clk0 == 0 && clk1 == 0, "R1 data low (ref low phase)", {clk0, clk1}, 0);

    // R2 / R3: reference pass-through on both outputs
    do_reset();
    @(posedge ref_clk); #5;
    check(clk0 == 1 && clk1 == 1, "R2 R3 ref pass high", {clk0, clk1}, 3);
    #10;
    check(clk0 == 0 && clk1 == 0, "R2 R3 ref pass low", {clk0, clk1}, 0);

    // R3: reference divided by two, via code 1 and via clk0 code 1 with code 3
    cfg_a = mk(1, 1, 7);
    do_reset();
    measure(1, 20);
    check_runs(1, 1, "R3 clk1 ref/2");
    cfg_a = mk(3, 1, 7);
    do_reset();
    measure(1, 20);
    check_runs(1, 1, "R3 clk1 clk0/2 of ref");

    // R2 R3 R4: sweep every P on both outputs
    for (int p = 0; p < 32; p++) begin
      int pe;
      pe = (p == 0) ? 1 : p;
      cfg_a = mk(3, (p % 2 == 0) ? 2 : 3, p);
      do_reset();
      measure(0, 6 * pe + 10);
      check_runs(pe, pe, (p == 0) ? "R4 clk0 P=0 half" : "R2 clk0 half period");
      measure(1, 10 * pe + 20);
      check_runs(2 * pe, 2 * pe, (p == 0) ? "R4 clk1 P=0 half" : "R3 clk1 div4P half");
    end

    // R2 R3: PLL pass-through and PLL divided by two
    cfg_a = mk(3, 0, 4);
    do_reset();
    repeat (4) @(posedge ref_clk);
    e0 = 0; e1 = 0;
    #600;
    check(e0 >= 98 && e0 <= 102, "R2 clk0 PLL edges", e0, 100);
    check(e1 >= 48 && e1 <= 52, "R3 clk1 PLL/2 edges", e1, 50);

    // R5 R6 R8: output-enable role, sync latency, clk1 follows clk0 source
    role = 2'd0; hiz0 = 1'b1; hiz1 = 1'b1; cfg_a = mk(2, 2, 3);
    do_reset();
    @(negedge ref_clk); pin = 1'b0;
    @(posedge ref_clk); #5;
    check(en0 == 1, "R5 one edge after pin low still enabled", en0, 1);
    @(posedge ref_clk); #5;
    check(en0 == 0, "R5 two edges after pin low released", en0, 0);
    check(clk0 == 0, "R8 released clk0 data low", clk0, 0);
    measure(1, 40);
    check_runs(3, 3, "R6 clk1 runs in OE low");
    check(en1 == 1, "R6 clk1 enabled in OE low", en1, 1);
    hiz0 = 1'b0;
    #1;
    check(en0 == 1, "R8 driven-low enable", en0, 1);
    measure(0, 20);
    check(nruns == 0 && clk0 == 0, "R8 driven-low stays low", clk0, 0);

    // R7 R8: power-down
    role = 2'd1; hiz0 = 1'b0; hiz1 = 1'b1; pin = 1'b1; cfg_a = mk(0, 2, 4);
    do_reset();
    @(negedge ref_clk); pin = 1'b0;
    repeat (3) @(posedge ref_clk); #5;
    check(clk0 == 0 && clk1 == 0, "R7 both silent (high phase)", {clk0, clk1}, 0);
    check(en0 == 1 && en1 == 0, "R8 power-down enables per hiz", {en0, en1}, 2);
    #10;
    check(clk0 == 0 && clk1 == 0, "R7 both silent (low phase)", {clk0, clk1}, 0);
    @(negedge ref_clk); pin = 1'b1;
    measure(0, 40);
    check_runs(4, 4, "R7 resume division");
    @(posedge ref_clk); #5;
    check(clk1 == 1 && en1 == 1, "R7 clk1 ref back", {clk1, en1}, 3);

    // R9: frequency select switches without runt phases
    role = 2'd2; pin = 1'b1; cfg_a = mk(0, 2, 3); cfg_b = mk(0, 2, 5);
    do_reset();
    measure(0, 30);
    check_runs(3, 3, "R9 pin high uses word A");
    @(negedge ref_clk); pin = 1'b0;
    measure(0, 60);
    check_runs(3, 5, "R9 no runt on switch");
    check(nruns >= 2 && runs[nruns-1] == 5, "R9 word B in use",
          (nruns > 0) ? runs[nruns-1] : -1, 5);
    @(negedge ref_clk); pin = 1'b1;
    measure(0, 60);
    check(nruns >= 2 && runs[nruns-1] == 3, "R9 back to word A",
          (nruns > 0) ? runs[nruns-1] : -1, 3);

    // R10: other roles use word A; pin-ignored role ignores a low pin
    role = 2'd1; pin = 1'b1; cfg_a = mk(0, 2, 2); cfg_b = mk(0, 2, 7);
    do_reset();
    measure(0, 30);
    check_runs(2, 2, "R10 power-down role uses word A");
    role = 2'd3; pin = 1'b0;
    do_reset();
    measure(0, 30);
    check_runs(2, 2, "R10 ignored pin keeps word A");
    check(en0 == 1 && en1 == 1, "R10 ignored pin keeps enables", {en0, en1}, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule